// File: doc/BRIEF.md
# Event-State Interrupt Source Bank

This block holds the event state of a bank of interrupt sources. Each source has a two-bit pending/queued state and an assertion flag. A configuration bit per source picks how the source behaves. An edge (message) source takes each high event as one trigger. A level source tracks whether its line is still asserted and never uses the queued bit. When a trigger or an end-of-interrupt means that an event has to go on to routing, the block emits a one-cycle notification that carries the source index.

Each cycle the block accepts at most one line event (source index plus the new line level) or one end-of-interrupt request. A small register port reads the state of any source at any time and can overwrite its pending/queued bits. Software uses that port to switch sources on, because every source leaves reset switched off. A write that puts a level source into a state it must never reach raises a one-cycle error pulse that carries the index.

Top module: `evsrc_array`

## Requirements
- R1: Reset sets every source to state 01 (off), clears every assertion flag and holds notification and error low. Reset does not touch the per-source type configuration.
- R2: The state encoding is bit 1 = pending (P) and bit 0 = queued (Q). For an edge source, a high event moves 00 to 10 and notifies. It moves 10 to 11, leaves 11 at 11 and leaves 01 at 01, and none of these three notifies.
- R3: An end-of-interrupt on an edge source moves 10 and 01 to 00 without notifying. It moves 11 to 10 and notifies. It leaves 00 at 00 without notifying.
- R4: A high event on a level source sets its assertion flag. If the state is 00 it becomes 10 and notifies. In any other state nothing else changes.
- R5: A low event on a level source clears its assertion flag and changes nothing else.
- R6: An end-of-interrupt on a level source first applies the R3 update. If the assertion flag is set, the R4 trigger rule is then applied to the result, and its outcome alone decides whether a notification is sent.
- R7: A low event on an edge source changes neither its state nor its flag, and it does not notify.
- R8: A notification is `ntf_valid` high for exactly one cycle, in the cycle after the operation, with `ntf_idx` equal to the source index.
- R9: When an end-of-interrupt and a line event arrive in the same cycle, only the end-of-interrupt is processed and the event is discarded.
- R10: `reg_rdata` and `reg_asserted` always show the current state and flag of source `reg_idx`, so a write sees the old value in the same cycle. A write replaces the state from the next cycle on and leaves the flag unchanged. If it hits the same source as an operation in that cycle, the write decides the state.
- R11: A register write of 11 to a level source makes `err_valid` high for one cycle in the next cycle, with `err_idx` equal to the index.
- R12: `cfg_we` sets the type of source `cfg_idx` (1 = level, 0 = edge) from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Type configuration write strobe |
| cfg_idx | input | IW | Source addressed by the configuration write |
| cfg_level | input | 1 | 1 = level source, 0 = edge source |
| ev_valid | input | 1 | Line event strobe |
| ev_idx | input | IW | Source of the line event |
| ev_high | input | 1 | New line level |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_idx | input | IW | Source of the end-of-interrupt |
| reg_we | input | 1 | State write strobe |
| reg_idx | input | IW | Source addressed by the register port |
| reg_wdata | input | 2 | New state {P,Q} |
| reg_rdata | output | 2 | Current state {P,Q} of `reg_idx` |
| reg_asserted | output | 1 | Current assertion flag of `reg_idx` |
| ntf_valid | output | 1 | Notification pulse |
| ntf_idx | output | IW | Index of the notifying source |
| err_valid | output | 1 | Illegal level-state pulse |
| err_idx | output | IW | Index of the offending source |

## Verification
The bench targets the end-of-interrupt on an asserted level source. A design that drops the re-trigger would leave the source stuck at 00 with the line still high. A design that keeps the plain end-of-interrupt outcome would notify a second time from state 11. An end-of-interrupt and an event on the same cycle check that the event is really discarded: a design that merged them would change the flag or notify. A reset issued after configuration checks that a level source still ignores Q. A design that cleared the type bits would start queueing on that source. Random mixes of events, end-of-interrupts and writes of all four state values are checked against an independent model, so the no-change transitions get covered too, including writes of 11 to level sources, which must raise the error pulse.

// File: rtl/evsrc_pkg.sv
package evsrc_pkg;

   localparam logic [1:0] PQ_IDLE = 2'b00;
   localparam logic [1:0] PQ_OFF  = 2'b01;
   localparam logic [1:0] PQ_SENT = 2'b10;
   localparam logic [1:0] PQ_BOTH = 2'b11;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_HIGH = 2'd1,
      OP_LOW  = 2'd2,
      OP_EOI  = 2'd3
   } evsrc_op_e;

   typedef struct packed {
      logic [1:0] pq;
      logic       fire;
   } pq_step_t;

   // Trigger on an edge source
   function automatic pq_step_t edge_trig(input logic [1:0] pq);
      pq_step_t r;
      r.fire = 1'b0;
      unique case (pq)
         PQ_IDLE: begin r.pq = PQ_SENT; r.fire = 1'b1; end
         PQ_SENT: r.pq = PQ_BOTH;
         PQ_BOTH: r.pq = PQ_BOTH;
         default: r.pq = PQ_OFF;
      endcase
      return r;
   endfunction

   // Trigger on a level source: only the idle state reacts
   function automatic pq_step_t level_trig(input logic [1:0] pq);
      pq_step_t r;
      r.pq   = pq;
      r.fire = 1'b0;
      if (pq == PQ_IDLE) begin
         r.pq   = PQ_SENT;
         r.fire = 1'b1;
      end
      return r;
   endfunction

   // End-of-interrupt update
   function automatic pq_step_t eoi_step(input logic [1:0] pq);
      pq_step_t r;
      r.fire = 1'b0;
      unique case (pq)
         PQ_BOTH: begin r.pq = PQ_SENT; r.fire = 1'b1; end
         default: r.pq = PQ_IDLE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/evsrc_cell.sv
module evsrc_cell
   import evsrc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic       cfg_level,
   input  logic       sel,
   input  evsrc_op_e  op,
   input  logic       wr_en,
   input  logic [1:0] wr_pq,
   output logic [1:0] pq_o,
   output logic       asrt_o,
   output logic       fire_o,
   output logic       bad_o
);

   logic       lvl_q;
   logic [1:0] pq_q, pq_n;
   logic       as_q, as_n;
   pq_step_t   r1, r2;

   // type configuration survives reset
   always_ff @(posedge clk) begin
      if (cfg_we) lvl_q <= cfg_level;
   end

   always_comb begin
      pq_n   = pq_q;
      as_n   = as_q;
      fire_o = 1'b0;
      r1     = '{pq: pq_q, fire: 1'b0};
      r2     = '{pq: pq_q, fire: 1'b0};
      if (sel) begin
         unique case (op)
            OP_HIGH: begin
               if (lvl_q) begin
                  as_n = 1'b1;
                  r1   = level_trig(pq_q);
               end else begin
                  r1   = edge_trig(pq_q);
               end
               pq_n   = r1.pq;
               fire_o = r1.fire;
            end
            OP_LOW: begin
               if (lvl_q) as_n = 1'b0;
            end
            OP_EOI: begin
               r1     = eoi_step(pq_q);
               pq_n   = r1.pq;
               fire_o = r1.fire;
               if (lvl_q && as_q) begin
                  r2     = level_trig(r1.pq);
                  pq_n   = r2.pq;
                  fire_o = r2.fire;
               end
            end
            default: ;
         endcase
      end
      if (wr_en) pq_n = wr_pq;
   end

   assign bad_o = wr_en && lvl_q && (wr_pq == PQ_BOTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pq_q <= PQ_OFF;
         as_q <= 1'b0;
      end else begin
         pq_q <= pq_n;
         as_q <= as_n;
      end
   end

   assign pq_o   = pq_q;
   assign asrt_o = as_q;

   // R5
   lvl_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_LOW && !wr_en) |=> $stable(pq_q));

   // R4
   busy_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_HIGH && pq_q != PQ_IDLE) |-> !fire_o);

   // R10
   wr_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel) |=> $stable(as_q));

endmodule

// File: rtl/evsrc_out.sv
module evsrc_out #(
   parameter int IW      = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic [IW-1:0] fire_idx,
   input  logic          bad,
   input  logic [IW-1:0] bad_idx,
   output logic          ntf_valid,
   output logic [IW-1:0] ntf_idx,
   output logic          err_valid,
   output logic [IW-1:0] err_idx
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ntf_valid <= 1'b0;
               ntf_idx   <= '0;
               err_valid <= 1'b0;
               err_idx   <= '0;
            end else begin
               ntf_valid <= fire;
               ntf_idx   <= fire_idx;
               err_valid <= bad;
               err_idx   <= bad_idx;
            end
         end

         // R8
         ntf_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ntf_valid |-> $past(fire));
      end else begin : g_comb
         assign ntf_valid = fire;
         assign ntf_idx   = fire_idx;
         assign err_valid = bad;
         assign err_idx   = bad_idx;
      end
   endgenerate

endmodule

// File: rtl/evsrc_array.sv
module evsrc_array
   import evsrc_pkg::*;
#(
   parameter int NSRC    = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int IW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [IW-1:0] cfg_idx,
   input  logic          cfg_level,
   input  logic          ev_valid,
   input  logic [IW-1:0] ev_idx,
   input  logic          ev_high,
   input  logic          eoi_valid,
   input  logic [IW-1:0] eoi_idx,
   input  logic          reg_we,
   input  logic [IW-1:0] reg_idx,
   input  logic [1:0]    reg_wdata,
   output logic [1:0]    reg_rdata,
   output logic          reg_asserted,
   output logic          ntf_valid,
   output logic [IW-1:0] ntf_idx,
   output logic          err_valid,
   output logic [IW-1:0] err_idx
);

   generate
      if (NSRC < 2) begin : g_bad_nsrc
         $error("evsrc_array: NSRC must be at least 2");
      end
      if (NSRC > 4096) begin : g_big_nsrc
         $error("evsrc_array: NSRC too large");
      end
   endgenerate

   evsrc_op_e       op;
   logic [IW-1:0]   op_idx;
   logic [NSRC-1:0] fire_vec;
   logic [NSRC-1:0] bad_vec;
   logic [1:0]      pq_arr [NSRC];
   logic            as_arr [NSRC];

   // end-of-interrupt wins over a line event
   always_comb begin
      op     = OP_NONE;
      op_idx = '0;
      if (eoi_valid) begin
         op     = OP_EOI;
         op_idx = eoi_idx;
      end else if (ev_valid) begin
         op     = ev_high ? OP_HIGH : OP_LOW;
         op_idx = ev_idx;
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_cell
      evsrc_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we && cfg_idx == IW'(i)),
         .cfg_level (cfg_level),
         .sel       (op_idx == IW'(i)),
         .op        (op),
         .wr_en     (reg_we && reg_idx == IW'(i)),
         .wr_pq     (reg_wdata),
         .pq_o      (pq_arr[i]),
         .asrt_o    (as_arr[i]),
         .fire_o    (fire_vec[i]),
         .bad_o     (bad_vec[i])
      );
   end

   always_comb begin
      reg_rdata    = PQ_OFF;
      reg_asserted = 1'b0;
      if (int'(reg_idx) < NSRC) begin
         reg_rdata    = pq_arr[reg_idx];
         reg_asserted = as_arr[reg_idx];
      end
   end

   evsrc_out #(.IW(IW), .REG_OUT(REG_OUT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (|fire_vec),
      .fire_idx (op_idx),
      .bad      (|bad_vec),
      .bad_idx  (reg_idx),
      .ntf_valid(ntf_valid),
      .ntf_idx  (ntf_idx),
      .err_valid(err_valid),
      .err_idx  (err_idx)
   );

   // R8
   single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fire_vec));

   // R9
   eoi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid |-> (op == OP_EOI && op_idx == eoi_idx));

   // R11
   bad_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|bad_vec) |-> reg_we);

endmodule

// File: tb/evsrc_array_bench.sv
module evsrc_array_bench;
   localparam int N  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_level = 0, ev_valid = 0, ev_high = 0;
   logic eoi_valid = 0, reg_we = 0;
   logic [IW-1:0] cfg_idx = 0, ev_idx = 0, eoi_idx = 0, reg_idx = 0;
   logic [1:0] reg_wdata = 0;
   logic [1:0] reg_rdata;
   logic reg_asserted, ntf_valid, err_valid;
   logic [IW-1:0] ntf_idx, err_idx;

   always #5 clk = ~clk;

   evsrc_array #(.NSRC(N)) u_evsrc_array (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_level(cfg_level), .ev_valid(ev_valid), .ev_idx(ev_idx),
      .ev_high(ev_high), .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_asserted(reg_asserted),
      .ntf_valid(ntf_valid), .ntf_idx(ntf_idx),
      .err_valid(err_valid), .err_idx(err_idx));

   int checks = 0;
   int errors = 0;
   logic [1:0] m_pq [N];
   bit m_as [N];
   bit m_lvl [N];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] e_trig(input logic [1:0] s, output bit f);
      f = 0;
      case (s)
         2'b00: begin f = 1; return 2'b10; end
         2'b10: return 2'b11;
         2'b11: return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   function automatic logic [1:0] l_trig(input logic [1:0] s, output bit f);
      f = (s == 2'b00);
      return f ? 2'b10 : s;
   endfunction

   function automatic logic [1:0] e_eoi(input logic [1:0] s, output bit f);
      f = (s == 2'b11);
      return f ? 2'b10 : 2'b00;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < N; i++) begin m_pq[i] = 2'b01; m_as[i] = 0; end
      chk(ntf_valid == 0 && err_valid == 0, "R1 outputs in reset", ntf_valid, 0);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic cfg(input int i, input bit lvl);
      cfg_we = 1; cfg_idx = IW'(i); cfg_level = lvl;
      m_lvl[i] = lvl;
      @(negedge clk);
      cfg_we = 0;
   endtask

   // one cycle of stimulus plus checks against the model
   task automatic step(input bit ev, input int ei, input bit hi,
                       input bit eo, input int oi,
                       input bit we, input int wi, input logic [1:0] wd,
                       input string tag);
      bit f, en_ntf, en_err;
      int en_idx;
      logic [1:0] old;
      ev_valid = ev; ev_idx = IW'(ei); ev_high = hi;
      eoi_valid = eo; eoi_idx = IW'(oi);
      reg_we = we; reg_idx = IW'(wi); reg_wdata = wd;
      f = 0; en_ntf = 0; en_idx = 0; en_err = 0;
      if (eo) begin
         m_pq[oi] = e_eoi(m_pq[oi], f);
         if (m_lvl[oi] && m_as[oi]) m_pq[oi] = l_trig(m_pq[oi], f);
         en_ntf = f; en_idx = oi;
      end else if (ev) begin
         if (m_lvl[ei]) begin
            m_as[ei] = hi;
            if (hi) m_pq[ei] = l_trig(m_pq[ei], f);
         end else if (hi) begin
            m_pq[ei] = e_trig(m_pq[ei], f);
         end
         en_ntf = f; en_idx = ei;
      end
      #1;
      if (we) begin
         old = m_pq[wi];
         chk(reg_rdata == old || (eo && oi == wi) || (ev && ei == wi),
             "R10 old value on write", reg_rdata, old);
         m_pq[wi] = wd;
         en_err = m_lvl[wi] && wd == 2'b11;
      end
      @(negedge clk);
      ev_valid = 0; eoi_valid = 0; reg_we = 0;
      chk(ntf_valid == en_ntf, {tag, " R8 ntf_valid"}, ntf_valid, en_ntf);
      if (en_ntf) chk(ntf_idx == IW'(en_idx), {tag, " R8 ntf_idx"}, ntf_idx, en_idx);
      chk(err_valid == en_err, {tag, " R11 err_valid"}, err_valid, en_err);
      if (en_err) chk(err_idx == IW'(wi), {tag, " R11 err_idx"}, err_idx, wi);
      reg_idx = IW'(eo ? oi : (ev ? ei : wi));
      #1;
      chk(reg_rdata == m_pq[reg_idx], {tag, " R10 state readback"}, reg_rdata, m_pq[reg_idx]);
      chk(reg_asserted == m_as[reg_idx], {tag, " R10 flag readback"}, reg_asserted, m_as[reg_idx]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0071));
      for (int i = 0; i < N; i++) m_lvl[i] = 0;
      do_reset();
      // R12: sources 0..3 level, 4..7 edge
      for (int i = 0; i < N; i++) cfg(i, i < 4);
      // R1: reset state readback
      for (int i = 0; i < N; i++) begin
         reg_idx = IW'(i); #1;
         chk(reg_rdata == 2'b01, "R1 reset state", reg_rdata, 1);
         chk(reg_asserted == 0, "R1 reset flag", reg_asserted, 0);
         @(negedge clk);
      end
      // R1: configuration survives a reset
      do_reset();
      step(0,0,0, 0,0, 1,1,2'b00, "R1 enable");
      step(1,1,1, 0,0, 0,0,2'b00, "R4 lvl high idle");
      step(1,1,1, 0,0, 0,0,2'b00, "R1 R4 lvl high again no Q");
      step(0,0,0, 1,1, 0,0,2'b00, "R6 eoi asserted refires");
      step(1,1,0, 0,0, 0,0,2'b00, "R5 lvl low");
      step(0,0,0, 1,1, 0,0,2'b00, "R6 eoi deasserted");
      // R2 R3 R7 on edge source 5
      step(0,0,0, 0,0, 1,5,2'b00, "R10 enable edge");
      step(1,5,1, 0,0, 0,0,2'b00, "R2 edge 00");
      step(1,5,1, 0,0, 0,0,2'b00, "R2 edge 10");
      step(1,5,1, 0,0, 0,0,2'b00, "R2 edge 11");
      step(1,5,0, 0,0, 0,0,2'b00, "R7 edge low");
      step(0,0,0, 1,5, 0,0,2'b00, "R3 eoi 11");
      step(0,0,0, 1,5, 0,0,2'b00, "R3 eoi 10");
      step(0,0,0, 1,5, 0,0,2'b00, "R3 eoi 00");
      // R9: event discarded when eoi arrives together
      step(1,2,1, 1,6, 0,0,2'b00, "R9 eoi wins");
      // R11: illegal state on level source
      step(0,0,0, 0,0, 1,3,2'b11, "R11 write 11 level");
      step(0,0,0, 0,0, 1,6,2'b11, "R11 write 11 edge");
      for (int k = 0; k < 600; k++) begin
         int kind = $urandom % 10;
         int a = $urandom % N;
         int b = $urandom % N;
         logic [1:0] wd = 2'($urandom);
         case (kind)
            0, 1, 2: step(1,a,1, 0,0, 0,0,2'b00, "R2 R4 rand high");
            3, 4:    step(1,a,0, 0,0, 0,0,2'b00, "R5 R7 rand low");
            5, 6:    step(0,0,0, 1,a, 0,0,2'b00, "R3 R6 rand eoi");
            7:       step(0,0,0, 0,0, 1,a,(wd == 2'b11 && ($urandom % 2)) ? 2'b00 : wd, "R10 rand write");
            8:       step(1,a,$urandom % 2, 1,b, 0,0,2'b00, "R9 rand both");
            default: step(1,a,1, 0,0, 1,b,2'b00, "R10 rand op+write");
         endcase
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule